// File: doc/BRIEF.md
# Low-Power Standby Mode Controller

This block decides when a small microcontroller core stops its own clock to save power, and which oscillators it may switch off while doing so. It offers two standby modes. The light mode gates only the CPU clock and keeps every oscillator running, so the core can resume on the next cycle. The deep mode also shuts down the high-speed crystal oscillator and the internal high-speed oscillator. Both modes end when an interrupt becomes pending. The subsystem oscillator and the low-speed oscillator are never switched off. The block never resets the core, so register, latch and port state is kept across standby.

Instruction decode sends one-cycle request pulses for the light and the deep mode. The deep mode is refused while the CPU runs on the subsystem clock; a refused request produces a one-cycle error pulse. When the core leaves deep standby and the crystal is the main clock source, the crystal needs time to settle. The block therefore holds the CPU clock off for a programmable number of cycles, counted on the always-running low-speed clock that also drives the block. A typical setting is 1024.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, mode_o is 00 (RUN). cpu_clk_en_o and cpu_run_o are 1, all four oscillator enables are 1, and stop_err_o is 0.
- R2: In RUN with no interrupt pending, a halt_req_i pulse without stop_req_i moves mode_o to 01 (HALT) at the next clock edge, for either value of sub_sel_i. In HALT, cpu_clk_en_o and cpu_run_o are 0 and all four oscillator enables stay 1.
- R3: In RUN with no interrupt pending and sub_sel_i=0, a stop_req_i pulse moves mode_o to 10 (STOP) at the next edge. In STOP, xtal_en_o, hsio_en_o, cpu_clk_en_o and cpu_run_o are 0, while lsio_en_o and sub_en_o stay 1.
- R4: In RUN with no interrupt pending and sub_sel_i=1, a stop_req_i pulse leaves mode_o at 00 and drives stop_err_o to 1 for exactly one cycle after the edge.
- R5: When halt_req_i and stop_req_i arrive together, only the stop request is handled. The result is STOP when sub_sel_i=0, and RUN with an error pulse when sub_sel_i=1.
- R6: A standby request that arrives while irq_pend_i is 1 is dropped. mode_o stays 00 and stop_err_o stays 0.
- R7: In HALT, irq_pend_i=1 returns mode_o to 00 at the next edge, with no wait.
- R8: In STOP with xtal_main_i=0, irq_pend_i=1 returns mode_o to 00 at the next edge.
- R9: In STOP with xtal_main_i=1, irq_pend_i=1 moves mode_o to 11 (WAIT_STAB). The value L on stab_len_i is captured at that edge. mode_o stays 11 for exactly L+1 cycles, and then returns to 00. During the wait, xtal_en_o and hsio_en_o are 1 and cpu_clk_en_o is 0.
- R10: Requests arriving in HALT, STOP or WAIT_STAB have no effect, and irq_pend_i has no effect during WAIT_STAB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed always-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | Light standby request pulse |
| stop_req_i | input | 1 | Deep standby request pulse |
| irq_pend_i | input | 1 | Any interrupt pending |
| sub_sel_i | input | 1 | 1: CPU runs on subsystem clock |
| xtal_main_i | input | 1 | 1: crystal is the main clock source |
| stab_len_i | input | CNT_W | Stabilization wait length in cycles |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| cpu_run_o | output | 1 | CPU running status |
| mode_o | output | 2 | 00 RUN, 01 HALT, 10 STOP, 11 WAIT_STAB |
| stop_err_o | output | 1 | Refused deep standby pulse |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| hsio_en_o | output | 1 | Internal high-speed oscillator enable |
| lsio_en_o | output | 1 | Internal low-speed oscillator enable |
| sub_en_o | output | 1 | Subsystem oscillator enable |

## Verification
A standby request and a pending interrupt can land in the same cycle. So can a halt request and a stop request. The bench sweeps every combination of halt, stop, interrupt, clock select and crystal flag from RUN. For each combination it computes the next mode and the error pulse from the priority rules: a pending interrupt drops the request, and otherwise the stop request is handled ahead of the halt request. The stabilization wait is judged by counting the samples in which the mode reads 11, for several lengths, and comparing the count with L+1.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_HALT = 2'b01,
    ST_STOP = 2'b10,
    ST_WAIT = 2'b11
  } sb_mode_e;

  localparam int unsigned NUM_OSC = 4;
  localparam int unsigned OSC_XTAL = 0;
  localparam int unsigned OSC_HSIO = 1;
  localparam int unsigned OSC_LSIO = 2;
  localparam int unsigned OSC_SUB  = 3;
endpackage

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     halt_req_i,
  input  logic     stop_req_i,
  input  logic     irq_pend_i,
  input  logic     sub_sel_i,
  input  logic     xtal_main_i,
  input  logic     stab_done_i,
  output logic     stab_load_o,
  output sb_mode_e state_o,
  output logic     err_o
);
  sb_mode_e state_q, state_d;
  logic     err_q, err_d;

  always_comb begin
    state_d     = state_q;
    err_d       = 1'b0;
    stab_load_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        // pending interrupt drops any request
        if (!irq_pend_i) begin
          if (stop_req_i) begin
            if (sub_sel_i) err_d = 1'b1;
            else           state_d = ST_STOP;
          end else if (halt_req_i) begin
            state_d = ST_HALT;
          end
        end
      end
      ST_HALT: if (irq_pend_i) state_d = ST_RUN;
      ST_STOP: begin
        if (irq_pend_i) begin
          if (xtal_main_i) begin
            state_d     = ST_WAIT;
            stab_load_o = 1'b1;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_WAIT: if (stab_done_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/osc_gate.sv
module osc_gate #(
  parameter int unsigned         N_OSC     = 4,
  parameter logic [N_OSC-1:0]    STOP_MASK = 4'b0011
) (
  input  logic             deep_i,
  output logic [N_OSC-1:0] en_o
);
  for (genvar i = 0; i < N_OSC; i++) begin : g_osc
    if (STOP_MASK[i]) begin : g_stoppable
      assign en_o[i] = !deep_i;
    end else begin : g_always
      assign en_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_req_i,
  input  logic             stop_req_i,
  input  logic             irq_pend_i,
  input  logic             sub_sel_i,
  input  logic             xtal_main_i,
  input  logic [CNT_W-1:0] stab_len_i,
  output logic             cpu_clk_en_o,
  output logic             cpu_run_o,
  output logic [1:0]       mode_o,
  output logic             stop_err_o,
  output logic             xtal_en_o,
  output logic             hsio_en_o,
  output logic             lsio_en_o,
  output logic             sub_en_o
);
  localparam logic [NUM_OSC-1:0] DEEP_MASK =
    NUM_OSC'((1 << OSC_XTAL) | (1 << OSC_HSIO));

  sb_mode_e           state;
  logic               stab_load, stab_done;
  logic [NUM_OSC-1:0] osc_en;

  standby_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_req_i  (halt_req_i),
    .stop_req_i  (stop_req_i),
    .irq_pend_i  (irq_pend_i),
    .sub_sel_i   (sub_sel_i),
    .xtal_main_i (xtal_main_i),
    .stab_done_i (stab_done),
    .stab_load_o (stab_load),
    .state_o     (state),
    .err_o       (stop_err_o)
  );

  stab_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stab_load),
    .len_i  (stab_len_i),
    .done_o (stab_done)
  );

  osc_gate #(.N_OSC(NUM_OSC), .STOP_MASK(DEEP_MASK)) u_osc (
    .deep_i (state == ST_STOP),
    .en_o   (osc_en)
  );

  assign cpu_clk_en_o = (state == ST_RUN);
  assign cpu_run_o    = (state == ST_RUN);
  assign mode_o       = state;
  assign xtal_en_o    = osc_en[OSC_XTAL];
  assign hsio_en_o    = osc_en[OSC_HSIO];
  assign lsio_en_o    = osc_en[OSC_LSIO];
  assign sub_en_o     = osc_en[OSC_SUB];
endmodule

// File: rtl/standby_chk.sv
module standby_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_req_i,
  input logic             stop_req_i,
  input logic             irq_pend_i,
  input logic             sub_sel_i,
  input logic             xtal_main_i,
  input logic [CNT_W-1:0] stab_len_i,
  input logic             cpu_clk_en_o,
  input logic [1:0]       mode_o,
  input logic             stop_err_o,
  input logic             xtal_en_o,
  input logic             hsio_en_o
);
  logic [CNT_W:0]   wcnt_q;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      len_q  <= '0;
    end else begin
      wcnt_q <= (mode_o == 2'b11) ? wcnt_q + 1'b1 : '0;
      if (mode_o == 2'b10 && irq_pend_i && xtal_main_i) len_q <= stab_len_i;
    end
  end

  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && !irq_pend_i && halt_req_i && !stop_req_i) |=> (mode_o == 2'b01)); // R2
  AST_HALT_OSC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01) |-> (xtal_en_o && hsio_en_o && !cpu_clk_en_o)); // R2
  AST_STOP_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |-> (!xtal_en_o && !hsio_en_o && !cpu_clk_en_o)); // R3
  AST_STOP_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && !irq_pend_i && stop_req_i && sub_sel_i) |=> (mode_o == 2'b00 && stop_err_o)); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_err_o) |-> ($past(stop_req_i) && $past(sub_sel_i) && $past(mode_o) == 2'b00)); // R4
  AST_IRQ_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && irq_pend_i) |=> (mode_o == 2'b00 && !stop_err_o)); // R6
  AST_HALT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && irq_pend_i) |=> (mode_o == 2'b00)); // R7
  AST_STOP_FAST_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && irq_pend_i && !xtal_main_i) |=> (mode_o == 2'b00)); // R8
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> (wcnt_q <= {1'b0, len_q} && !cpu_clk_en_o && xtal_en_o)); // R9
  AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11 && wcnt_q == {1'b0, len_q}) |=> (mode_o == 2'b00)); // R9
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && !irq_pend_i) |=> (mode_o == 2'b10)); // R10
endmodule

bind standby_ctrl standby_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .halt_req_i   (halt_req_i),
  .stop_req_i   (stop_req_i),
  .irq_pend_i   (irq_pend_i),
  .sub_sel_i    (sub_sel_i),
  .xtal_main_i  (xtal_main_i),
  .stab_len_i   (stab_len_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .mode_o       (mode_o),
  .stop_err_o   (stop_err_o),
  .xtal_en_o    (xtal_en_o),
  .hsio_en_o    (hsio_en_o)
);

// File: tb/standby_ctrl_test.sv
`timescale 1ns/1ps
module standby_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_req, stop_req, irq, sub_sel, xtal_main;
  logic [CNT_W-1:0] stab_len;
  logic cpu_clk_en, cpu_run, stop_err, xtal_en, hsio_en, lsio_en, sub_en;
  logic [1:0] mode;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctrl #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .halt_req_i(halt_req), .stop_req_i(stop_req),
    .irq_pend_i(irq), .sub_sel_i(sub_sel), .xtal_main_i(xtal_main), .stab_len_i(stab_len),
    .cpu_clk_en_o(cpu_clk_en), .cpu_run_o(cpu_run), .mode_o(mode), .stop_err_o(stop_err),
    .xtal_en_o(xtal_en), .hsio_en_o(hsio_en), .lsio_en_o(lsio_en), .sub_en_o(sub_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    halt_req = 0; stop_req = 0; irq = 0;
  endtask

  // status vector: {cpu_clk_en, cpu_run, mode, err, xtal, hsio, lsio, sub}
  function automatic logic [31:0] stat();
    return {23'd0, cpu_clk_en, cpu_run, mode, stop_err, xtal_en, hsio_en, lsio_en, sub_en};
  endfunction

  function automatic logic [31:0] exp_stat(input logic [1:0] m, input logic err);
    logic run = (m == 2'b00);
    logic deep = (m == 2'b10);
    return {23'd0, run, run, m, err, ~deep, ~deep, 1'b1, 1'b1};
  endfunction

  task automatic go_run();
    idle(); irq = 1; step(); step(); irq = 0; step(); step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(); sub_sel = 0; xtal_main = 0; stab_len = 16'd3;
    #(CLK_PERIOD * 2 + 1);
    check("R1", stat(), exp_stat(2'b00, 1'b0));
    rst_ni = 1'b1;
    step();
    check("R1", stat(), exp_stat(2'b00, 1'b0));

    // R2 R3 R4 R5 R6: sweep every request combination from RUN
    for (int v = 0; v < 32; v++) begin
      logic h, s, i, ss, xm;
      logic [1:0] em; logic ee;
      {h, s, i, ss, xm} = v[4:0];
      go_run();
      sub_sel = ss; xtal_main = xm;
      halt_req = h; stop_req = s; irq = i;
      em = 2'b00; ee = 1'b0;
      if (!i) begin
        if (s) begin
          if (ss) ee = 1'b1; else em = 2'b10;
        end else if (h) em = 2'b01;
      end
      step();
      idle();
      if (h && s) check("R5", stat(), exp_stat(em, ee));
      else if (i) check("R6", stat(), exp_stat(em, ee));
      else if (s && ss) check("R4", stat(), exp_stat(em, ee));
      else if (s) check("R3", stat(), exp_stat(em, ee));
      else check("R2", stat(), exp_stat(em, ee));
      step();
      check("R4", {31'd0, stop_err}, 32'd0);
      check("R10", {30'd0, mode}, {30'd0, em});
      // R10: requests in standby have no effect
      if (em != 2'b00) begin
        halt_req = 1; stop_req = 1; step(); idle(); step();
        check("R10", {30'd0, mode}, {30'd0, em});
        irq = 1; step(); irq = 0;
        if (em == 2'b01) check("R7", stat(), exp_stat(2'b00, 1'b0));
        else if (!xm) check("R8", stat(), exp_stat(2'b00, 1'b0));
        else check("R9", stat(), exp_stat(2'b11, 1'b0));
      end
    end

    // R9: stabilization wait length sweep
    for (int k = 0; k < 12; k++) begin
      int len, cnt;
      len = (k < 10) ? k : ((k == 10) ? 37 : 1024);
      go_run();
      sub_sel = 0; xtal_main = 1; stab_len = 16'(len);
      stop_req = 1; step(); idle();
      check("R3", {30'd0, mode}, 32'd2);
      irq = 1; step(); irq = 0;
      stab_len = 16'hffff; // changed after capture
      cnt = 0;
      while (mode == 2'b11 && cnt < 5000) begin
        if (cnt == 0) check("R9", {29'd0, cpu_clk_en, xtal_en, hsio_en}, 32'b011);
        // R10: inputs during the wait are ignored
        irq = (cnt % 2 == 1); halt_req = (cnt % 3 == 0); stop_req = (cnt % 3 == 1);
        cnt++;
        step();
      end
      idle();
      check("R9", 32'(cnt), 32'(len + 1));
      check("R9", stat(), exp_stat(2'b00, 1'b0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule